// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block holds the modem status byte of a 16550-style serial port. It watches four active-low handshake pins (clear-to-send, data-set-ready, ring indicator and carrier detect). It brings each pin into the core clock domain through a synchronizer. It reports the active-high level of each line in the upper nibble and a sticky change flag for each line in the lower nibble. When any change flag is set and the enable input is high, it requests a modem status interrupt.

In loopback mode the four pins are ignored. The four modem-control outputs (RTS, DTR, OUT1, OUT2) stand in for them and drive the status bits. Change detection then runs on these substituted sources, so toggling a control output raises the matching flag. A read strobe returns the byte and clears the change flags on the same clock edge. A change that lands on that edge stays recorded.

Top module: `mstat_reg`

## Requirements
- R1: Outside loopback, rd_data[4], [5], [6] and [7] show the inverted levels of cts_n_i, dsr_n_i, ri_n_i and dcd_n_i. A pin change appears there on the third rising clock edge after it is applied.
- R2: rd_data[0] becomes 1 when the clear-to-send level (rd_data[4]) changes in either direction.
- R3: rd_data[1] becomes 1 when the data-set-ready level (rd_data[5]) changes in either direction.
- R4: rd_data[2] becomes 1 only when the ring level (rd_data[6]) goes from 1 to 0. A 0-to-1 ring change leaves it unchanged.
- R5: rd_data[3] becomes 1 when the carrier level (rd_data[7]) changes in either direction.
- R6: With lpbk_en = 1, rd_data[4], [5], [6] and [7] follow mc_rts, mc_dtr, mc_out1 and mc_out2 one edge later, and the four pins have no effect on rd_data.
- R7: In loopback, changes of mc_rts, mc_dtr, mc_out1 and mc_out2 set rd_data[0], [1], [2] and [3] under the same rules as R2 to R5.
- R8: A clock edge with rd_stb = 1 clears rd_data[3:0]. A change detected on that same edge leaves its flag set.
- R9: irq is 1 exactly when irq_en = 1 and at least one of rd_data[3:0] is 1.
- R10: While rst_n = 0, rd_data is 0 and irq is 0. After reset the level bits settle to the current sources without setting any change flag.
- R11: A change flag that is set stays set until an edge with rd_stb = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | Register read strobe; clears change flags on this edge |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| ri_n_i | input | 1 | Ring indicator pin, active low |
| dcd_n_i | input | 1 | Carrier detect pin, active low |
| lpbk_en | input | 1 | Loopback select from the modem control register |
| mc_rts | input | 1 | RTS control bit, loopback source for bit 4 |
| mc_dtr | input | 1 | DTR control bit, loopback source for bit 5 |
| mc_out1 | input | 1 | OUT1 control bit, loopback source for bit 6 |
| mc_out2 | input | 1 | OUT2 control bit, loopback source for bit 7 |
| irq_en | input | 1 | Modem status interrupt enable |
| rd_data | output | 8 | Status byte: levels in [7:4], change flags in [3:0] |
| irq | output | 1 | Modem status interrupt request |

## Verification
The assertions assume that each level bit in rd_data moves only when its source moves. They also assume that the loopback control inputs come from the same clock domain, so they can be compared with a one-edge delay. The bench drives every input on the falling edge and holds each new pin pattern longer than the synchronizer depth. It sweeps all 256 transitions between nibble patterns, once on the pins and once on the loopback sources. Each pattern is allowed to settle and be cleared before the next transition, so every flag observed comes from one known level change.

// File: rtl/mstat_pkg.sv
// Package: shared widths, bit positions and edge rules for the modem status block.
// Assumes four status lines in the order CTS, DSR, RI, DCD (bit 0 .. bit 3).
package mstat_pkg;
    localparam int unsigned LINES      = 4;
    localparam int unsigned SYNC_DEPTH = 2;
    localparam int unsigned CTS_IDX    = 0;
    localparam int unsigned DSR_IDX    = 1;
    localparam int unsigned RI_IDX     = 2;
    localparam int unsigned DCD_IDX    = 3;
    // Lines whose change flag fires only on the active-to-inactive edge.
    localparam logic [LINES-1:0] FALL_ONLY = 4'b0100;
endpackage

// File: rtl/mstat_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; resets to RST_VAL (inactive pin level).
module mstat_sync #(
    parameter int unsigned W       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];

    // Shift the pin samples down the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= {W{RST_VAL}};
        end else begin
            stg_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/mstat_srcsel.sv
// Module: chooses between synchronized pin levels and loopback control bits.
// Assumes pins are active low; control bits are already active high and in-domain.
module mstat_srcsel #(
    parameter int unsigned W = 4
) (
    input  logic         lpbk_en,
    input  logic [W-1:0] pin_sync_n,
    input  logic [W-1:0] loop_src,
    output logic [W-1:0] level_src
);
    // Substitute the control bits for the inverted pins in loopback.
    always_comb begin
        level_src = lpbk_en ? loop_src : ~pin_sync_n;
    end
endmodule

// File: rtl/mstat_delta.sv
// Module: per-line level register and sticky change flag with clear-on-read.
// Assumes src is synchronous; arm gates detection while the sync chain fills.
module mstat_delta #(
    parameter int unsigned W         = 4,
    parameter logic [W-1:0] FALL_ONLY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic         rd_clr,
    input  logic [W-1:0] src,
    output logic [W-1:0] lvl,
    output logic [W-1:0] flag
);
    logic [W-1:0] lvl_q;
    logic [W-1:0] flag_q;
    logic [W-1:0] chg;

    for (genvar i = 0; i < W; i++) begin : g_line
        if (FALL_ONLY[i]) begin : g_fall
            // Detect only the active-to-inactive transition.
            always_comb chg[i] = arm & lvl_q[i] & ~src[i];
        end else begin : g_any
            // Detect a transition in either direction.
            always_comb chg[i] = arm & (lvl_q[i] ^ src[i]);
        end

        // Track the level and hold the sticky change flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[i]  <= 1'b0;
                flag_q[i] <= 1'b0;
            end else begin
                lvl_q[i]  <= src[i];
                flag_q[i] <= (flag_q[i] & ~rd_clr) | chg[i];
            end
        end
    end

    assign lvl  = lvl_q;
    assign flag = flag_q;
endmodule

// File: rtl/mstat_reg.sv
// Module: modem status register top. Synchronizes pins, applies loopback,
// detects changes, clears flags on read and raises the interrupt request.
// Assumes control inputs and rd_stb are in the clk domain.
module mstat_reg
    import mstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_stb,
    input  logic       cts_n_i,
    input  logic       dsr_n_i,
    input  logic       ri_n_i,
    input  logic       dcd_n_i,
    input  logic       lpbk_en,
    input  logic       mc_rts,
    input  logic       mc_dtr,
    input  logic       mc_out1,
    input  logic       mc_out2,
    input  logic       irq_en,
    output logic [7:0] rd_data,
    output logic       irq
);
    localparam int unsigned SETTLE = SYNC_DEPTH + 1;
    localparam int unsigned CNT_W  = $clog2(SETTLE + 1);

    logic [LINES-1:0] pin_n;
    logic [LINES-1:0] pin_sync_n;
    logic [LINES-1:0] loop_src;
    logic [LINES-1:0] level_src;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] flag;
    logic [CNT_W-1:0] settle_q;
    logic             arm_q;

    assign pin_n    = {dcd_n_i, ri_n_i, dsr_n_i, cts_n_i};
    assign loop_src = {mc_out2, mc_out1, mc_dtr, mc_rts};

    mstat_sync #(.W(LINES), .STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_n),
        .sync_o  (pin_sync_n)
    );

    mstat_srcsel #(.W(LINES)) u_sel (
        .lpbk_en    (lpbk_en),
        .pin_sync_n (pin_sync_n),
        .loop_src   (loop_src),
        .level_src  (level_src)
    );

    // Hold detection off until the synchronizer and level register are filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (settle_q != CNT_W'(SETTLE)) begin
            settle_q <= settle_q + 1'b1;
        end
    end

    assign arm_q = (settle_q == CNT_W'(SETTLE));

    mstat_delta #(.W(LINES), .FALL_ONLY(FALL_ONLY)) u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm_q),
        .rd_clr (rd_stb),
        .src    (level_src),
        .lvl    (lvl),
        .flag   (flag)
    );

    // Assemble the status byte and the gated interrupt request.
    always_comb begin
        rd_data = {lvl, flag};
        irq     = irq_en & (|flag);
    end
endmodule

// File: rtl/mstat_reg_chk.sv
// Module: assertion checker for mstat_reg, attached with bind below.
// Assumes control inputs are synchronous to clk.
module mstat_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       lpbk_en,
    input logic       mc_rts,
    input logic       mc_dtr,
    input logic       mc_out1,
    input logic       mc_out2,
    input logic       irq_en,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic       armed
);
    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    p_irq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && (|rd_data[3:0])) |-> irq);
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));
    p_cts_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(armed) && rd_data[4] != $past(rd_data[4])) |-> rd_data[0]);
    p_dsr_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(armed) && rd_data[5] != $past(rd_data[5])) |-> rd_data[1]);
    p_ri_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(armed) && $past(rd_data[6]) && !rd_data[6]) |-> rd_data[2]);
    p_ri_rise_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[2]) |-> $fell(rd_data[6]));
    p_dcd_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(armed) && rd_data[7] != $past(rd_data[7])) |-> rd_data[3]);
    p_loop_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lpbk_en)) |->
        (rd_data[7:4] == $past({mc_out2, mc_out1, mc_dtr, mc_rts})));
    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb ##1 (rd_data[7:4] == $past(rd_data[7:4])) |-> (rd_data[3:0] == 4'h0));
endmodule

bind mstat_reg mstat_reg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .lpbk_en (lpbk_en),
    .mc_rts  (mc_rts),
    .mc_dtr  (mc_dtr),
    .mc_out1 (mc_out1),
    .mc_out2 (mc_out2),
    .irq_en  (irq_en),
    .rd_data (rd_data),
    .irq     (irq),
    .armed   (arm_q)
);

// File: tb/mstat_reg_bench.sv
module mstat_reg_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_stb = 1'b0;
    logic       cts_n_i = 1'b1, dsr_n_i = 1'b1, ri_n_i = 1'b1, dcd_n_i = 1'b1;
    logic       lpbk_en = 1'b0;
    logic       mc_rts = 1'b0, mc_dtr = 1'b0, mc_out1 = 1'b0, mc_out2 = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mstat_reg u_mstat_reg (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb),
        .cts_n_i(cts_n_i), .dsr_n_i(dsr_n_i), .ri_n_i(ri_n_i), .dcd_n_i(dcd_n_i),
        .lpbk_en(lpbk_en), .mc_rts(mc_rts), .mc_dtr(mc_dtr),
        .mc_out1(mc_out1), .mc_out2(mc_out2), .irq_en(irq_en),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Active-high levels: bit0 CTS, bit1 DSR, bit2 RI, bit3 DCD.
    task automatic set_pins(input logic [3:0] act);
        cts_n_i = ~act[0]; dsr_n_i = ~act[1]; ri_n_i = ~act[2]; dcd_n_i = ~act[3];
    endtask

    task automatic set_ctl(input logic [3:0] v);
        mc_rts = v[0]; mc_dtr = v[1]; mc_out1 = v[2]; mc_out2 = v[3];
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        edges(1);
        rd_stb = 1'b0;
    endtask

    function automatic logic [3:0] exp_flags(input logic [3:0] a, input logic [3:0] b);
        return ((a ^ b) & 4'b1011) | (a & ~b & 4'b0100);
    endfunction

    task automatic transition(input bit loop, input logic [3:0] a, input logic [3:0] b);
        if (loop) set_ctl(a); else set_pins(a);
        edges(4);
        do_read();
        if (loop) set_ctl(b); else set_pins(b);
        edges(loop ? 1 : 3);
        if (loop) chk("R6 R7 loopback level and flags", rd_data, {b, exp_flags(a, b)});
        else      chk("R1 R2 R3 R4 R5 pin level and flags", rd_data, {b, exp_flags(a, b)});
        do_read();
        chk("R8 flags cleared by read", {4'h0, rd_data[3:0]}, 8'h00);
    endtask

    initial begin
        set_pins(4'hF);
        irq_en = 1'b1;
        edges(3);
        chk("R10 status zero in reset", rd_data, 8'h00);
        chk("R10 irq low in reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        edges(6);
        chk("R10 levels settle without flags", rd_data, 8'hF0);
        chk("R10 no irq after settle", {7'b0, irq}, 8'h00);

        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                transition(1'b0, 4'(a), 4'(b));

        // Loopback: pins held, control bits drive the levels.
        set_pins(4'h0);
        set_ctl(4'h0);
        edges(4);
        do_read();
        lpbk_en = 1'b1;
        edges(2);
        do_read();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                transition(1'b1, 4'(a), 4'(b));

        // Pins ignored in loopback.
        set_ctl(4'h5);
        edges(2);
        do_read();
        set_pins(4'hA);
        edges(4);
        chk("R6 pins ignored in loopback", rd_data, 8'h50);
        set_pins(4'h0);
        edges(4);
        chk("R6 pins ignored in loopback again", rd_data, 8'h50);

        // Change on the read edge survives; others are cleared.
        set_ctl(4'h0);
        edges(2);
        do_read();
        mc_dtr = 1'b1;
        edges(1);
        chk("R11 dtr flag set", {4'h0, rd_data[3:0]}, 8'h02);
        edges(3);
        chk("R11 dtr flag held", {4'h0, rd_data[3:0]}, 8'h02);
        mc_rts = 1'b1;
        rd_stb = 1'b1;
        edges(1);
        rd_stb = 1'b0;
        chk("R8 coincident change kept", rd_data, 8'h31);

        // Interrupt gating.
        irq_en = 1'b0;
        edges(1);
        chk("R9 irq masked", {7'b0, irq}, 8'h00);
        irq_en = 1'b1;
        edges(1);
        chk("R9 irq raised", {7'b0, irq}, 8'h01);
        do_read();
        chk("R9 irq drops after read", {7'b0, irq}, 8'h00);
        mc_out2 = 1'b1;
        edges(1);
        chk("R9 irq on new flag", {7'b0, irq}, 8'h01);

        // Reset with flags pending.
        rst_n = 1'b0;
        edges(2);
        chk("R10 reset clears flags", rd_data, 8'h00);
        lpbk_en = 1'b0;
        set_pins(4'h3);
        rst_n = 1'b1;
        edges(6);
        chk("R10 settle to pins after reset", rd_data, 8'h30);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule